// File: doc/BRIEF.md
# Conditional Relative Branch Sequencer

This block carries out the operand and branch part of the two conditional relative jumps of an 8-bit processor: "jump if the zero flag is set" and "jump if the zero flag is clear". It starts after the opcode byte has already been fetched. At that point the program counter addresses the operand byte. A start pulse carries the condition select and the current zero flag.

The sequencer reads the operand byte through a synchronous memory read port and treats it as a signed 8-bit displacement. It steps the program counter past the operand, then evaluates the condition. A taken branch adds the sign-extended displacement to the stepped counter, and a branch that is not taken leaves it there. Machine cycles are paced by a clock-per-machine-cycle counter. A taken branch spends one extra machine cycle. On completion the block raises a one-clock done pulse and reports the machine-cycle count and the branch decision.

Top module: `branch_seq`

## Requirements
- R1: After reset, pc_o is 0x0000, and busy_o, done_o, mem_rd_o, taken_o are 0 and mcycles_o is 0.
- R2: A start_i seen high at a clock edge while busy_o is low is accepted. busy_o is high from the next clock. mem_rd_o is high for exactly the first clock after acceptance, with mem_addr_o equal to the program counter at acceptance.
- R3: Read data is valid one clock after the strobe. The displacement is the mem_data_i value present in the second clock after acceptance, and it is taken as two's complement.
- R4: With cond_sel_i = 1 the branch is taken when zero_i = 1. With cond_sel_i = 0 it is taken when zero_i = 0. Both values are those sampled with the accepted start. taken_o shows the decision from the done pulse until the next completion.
- R5: A taken branch leaves pc_o = (acceptance PC + 1 + sign-extended displacement) mod 2^16.
- R6: A branch that is not taken leaves pc_o = acceptance PC + 1.
- R7: With 4 clocks per machine cycle, done_o is high for one clock that starts 12 clocks after acceptance for a taken branch and 8 clocks after acceptance otherwise. busy_o is low during that clock.
- R8: At the done pulse, mcycles_o shows 3 for a taken branch and 2 otherwise, and it holds that value until the next completion.
- R9: start_i is ignored while busy_o is high. It changes neither the outcome nor the length of the instruction in progress, and no new instruction begins.
- R10: While the block is idle and start_i is low, pc_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a branch instruction |
| cond_sel_i | input | 1 | 1: branch when zero set; 0: branch when zero clear |
| zero_i | input | 1 | Zero flag value for this instruction |
| mem_data_i | input | 8 | Read data, valid one clock after the strobe |
| mem_addr_o | output | 16 | Read address (current program counter) |
| mem_rd_o | output | 1 | Read strobe |
| pc_o | output | 16 | Program counter |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-clock completion pulse |
| taken_o | output | 1 | Decision of the last completed branch |
| mcycles_o | output | 2 | Machine cycles of the last completed branch |

## Verification
The bench uses the displacement extremes 0x7F, 0x80, 0x00 and 0xFF, and negative steps from near address zero so the target wraps below 0x0000. A design that dropped the sign extension or added the offset before stepping past the operand would land on the wrong address. The memory model returns a filler byte in every clock except the one right after the strobe, so a design that samples the operand a clock late picks up that filler. Each instruction's length is counted clock by clock, which catches a taken branch that ends after 8 clocks or a done pulse that lasts two clocks. A second start is pulsed with the opposite condition mid-instruction: a design that accepted it would flip the decision or restart its timing.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  localparam int MC_NOT_TAKEN = 2;
  localparam int MC_TAKEN     = 3;
  localparam int MC_W         = $clog2(MC_TAKEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_OFS,
    ST_EVAL,
    ST_EXTRA
  } seq_state_e;
endpackage

// File: rtl/branch_mc_timer.sv
module branch_mc_timer #(
  parameter int CLK_PER_MC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic first_o,
  output logic sample_o,
  output logic last_o
);
  localparam int SUB_W = (CLK_PER_MC > 2) ? $clog2(CLK_PER_MC) : 1;
  localparam logic [SUB_W-1:0] LAST = SUB_W'(CLK_PER_MC - 1);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sub_q <= '0;
    else if (clear_i)      sub_q <= '0;
    else if (run_i)        sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
  end

  assign first_o  = (sub_q == '0);
  assign sample_o = (sub_q == SUB_W'(1));
  assign last_o   = (sub_q == LAST);

  a_r7_sub_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= LAST);
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && last_o) |=> first_o);
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval (
  input  logic sel_i,
  input  logic zero_i,
  output logic taken_o
);
  // sel 1: branch on zero set; sel 0: branch on zero clear
  assign taken_o = sel_i ? zero_i : ~zero_i;
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] ofs_i,
  output logic [ADDR_W-1:0] step_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{ofs_i[DATA_W-1]}}, ofs_i};
    end else begin : g_trunc
      assign ofs_ext = ofs_i[ADDR_W-1:0];
    end
  endgenerate

  assign step_o   = pc_i + 1'b1;
  assign target_o = pc_i + ofs_ext;
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_PER_MC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cond_sel_i,
  input  logic              zero_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [MC_W-1:0]   mcycles_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ofs_q;
  logic              sel_q, zero_q, done_q, taken_q;
  logic [MC_W-1:0]   mcyc_q;

  logic accept, mc_first, mc_sample, mc_last, take;
  logic [ADDR_W-1:0] pc_step, pc_target;

  assign accept = (state_q == ST_IDLE) && start_i;

  branch_mc_timer #(.CLK_PER_MC(CLK_PER_MC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .run_i   (state_q != ST_IDLE),
    .first_o (mc_first),
    .sample_o(mc_sample),
    .last_o  (mc_last)
  );

  branch_cond_eval u_cond (
    .sel_i  (sel_q),
    .zero_i (zero_q),
    .taken_o(take)
  );

  branch_target_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
    .pc_i    (pc_q),
    .ofs_i   (ofs_q),
    .step_o  (pc_step),
    .target_o(pc_target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ofs_q   <= '0;
      sel_q   <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      mcyc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sel_q   <= cond_sel_i;
            zero_q  <= zero_i;
            state_q <= ST_FETCH_OFS;
          end
        end
        ST_FETCH_OFS: begin
          // data arrives the clock after the strobe; step past the operand
          if (mc_sample) begin
            ofs_q <= mem_data_i;
            pc_q  <= pc_step;
          end
          if (mc_last) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (mc_last) begin
            if (take) begin
              pc_q    <= pc_target;
              state_q <= ST_EXTRA;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              taken_q <= 1'b0;
              mcyc_q  <= MC_W'(MC_NOT_TAKEN);
            end
          end
        end
        ST_EXTRA: begin
          if (mc_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            taken_q <= 1'b1;
            mcyc_q  <= MC_W'(MC_TAKEN);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o = pc_q;
  assign mem_rd_o   = (state_q == ST_FETCH_OFS) && mc_first;
  assign pc_o       = pc_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign taken_o    = taken_q;
  assign mcycles_o  = mcyc_q;

  a_r2_rd_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);
  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r3_sample_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH_OFS && mc_sample) |-> $past(mem_rd_o));
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_mcyc_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mcycles_o == (taken_o ? MC_W'(MC_TAKEN) : MC_W'(MC_NOT_TAKEN))));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !mc_last) |=> busy_o);
  a_r10_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(pc_o));
endmodule

// File: tb/tb_branch_seq.sv
`timescale 1ns/1ps
module tb_branch_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, cond_sel_i = 1'b0, zero_i = 1'b0;
  logic [7:0]  mem_data_i;
  logic [15:0] mem_addr_o, pc_o;
  logic        mem_rd_o, busy_o, done_o, taken_o;
  logic [1:0]  mcycles_o;
  logic [7:0]  stim_ofs = 8'h00;
  logic [15:0] pc_exp = 16'h0000;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  // synchronous read port: data the clock after the strobe, filler otherwise
  always @(posedge clk_i) mem_data_i <= mem_rd_o ? stim_ofs : 8'hA5;

  branch_seq dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_pc(input logic [15:0] pc, input logic tk,
                                         input logic [7:0] ofs);
    return tk ? (pc + 16'd1 + {{8{ofs[7]}}, ofs}) : (pc + 16'd1);
  endfunction

  task automatic run_br(input logic cs, input logic z, input logic [7:0] ofs,
                        input bit poke);
    logic tk;
    logic [15:0] exp_pc;
    int n;
    tk = cs ? z : ~z;
    exp_pc = ref_pc(pc_exp, tk, ofs);
    @(negedge clk_i);
    start_i = 1'b1; cond_sel_i = cs; zero_i = z; stim_ofs = ofs;
    @(negedge clk_i);
    start_i = 1'b0; n = 1;
    chk(busy_o == 1'b1, "R2", "busy", 32'(busy_o), 1);
    chk(mem_rd_o == 1'b1, "R2", "strobe", 32'(mem_rd_o), 1);
    chk(mem_addr_o == pc_exp, "R2", "addr", 32'(mem_addr_o), 32'(pc_exp));
    @(negedge clk_i);
    n = 2;
    chk(mem_rd_o == 1'b0, "R2", "strobe width", 32'(mem_rd_o), 0);
    while (!done_o && n < 40) begin
      @(negedge clk_i);
      n++;
      if (poke && n == 3) begin start_i = 1'b1; cond_sel_i = ~cs; zero_i = z; end
      if (n == 4) start_i = 1'b0;
    end
    chk(n == (tk ? 13 : 9), poke ? "R9" : "R7", "latency", 32'(n), tk ? 13 : 9);
    chk(busy_o == 1'b0, "R7", "busy at done", 32'(busy_o), 0);
    chk(pc_o == exp_pc, tk ? "R5" : "R6", "pc", 32'(pc_o), 32'(exp_pc));
    chk(taken_o == tk, poke ? "R9" : "R4", "taken", 32'(taken_o), 32'(tk));
    chk(mcycles_o == (tk ? 2'd3 : 2'd2), "R8", "mcycles", 32'(mcycles_o), tk ? 3 : 2);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7", "done width", 32'(done_o), 0);
    chk(busy_o == 1'b0, "R9", "no restart", 32'(busy_o), 0);
    chk(mcycles_o == (tk ? 2'd3 : 2'd2), "R8", "mcycles hold", 32'(mcycles_o), tk ? 3 : 2);
    pc_exp = exp_pc;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pc_o == 16'h0000, "R1", "pc", 32'(pc_o), 0);
    chk(busy_o == 1'b0 && done_o == 1'b0 && mem_rd_o == 1'b0, "R1", "ctl",
        {29'd0, busy_o, done_o, mem_rd_o}, 0);
    chk(taken_o == 1'b0 && mcycles_o == 2'd0, "R1", "status",
        {29'd0, taken_o, mcycles_o}, 0);

    // negative step from near zero wraps (R5)
    run_br(1'b1, 1'b1, 8'h80, 1'b0);
    run_br(1'b0, 1'b0, 8'h7F, 1'b0);
    run_br(1'b0, 1'b1, 8'hFF, 1'b0);
    run_br(1'b1, 1'b0, 8'h12, 1'b0);
    run_br(1'b1, 1'b1, 8'hFF, 1'b0);
    run_br(1'b0, 1'b0, 8'h00, 1'b0);
    // R9: second start mid-instruction with opposite select
    run_br(1'b1, 1'b1, 8'h05, 1'b1);
    run_br(1'b0, 1'b1, 8'h05, 1'b1);

    // R10: idle hold
    begin
      logic [15:0] held;
      held = pc_o;
      repeat (6) @(negedge clk_i);
      chk(pc_o == held && !busy_o, "R10", "idle pc", 32'(pc_o), 32'(held));
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_br(r[0], r[1], r[15:8], r[7:2] == 6'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule